// File: doc/BRIEF.md
# Data-Transport Microsequencer

This block is a small non-pipelined controller that runs a stored program of 32-bit instructions and copies words from an output buffer into an input buffer. Its only arithmetic is addition, used to form buffer addresses from a 16-entry by 16-bit register file and a signed immediate. The instruction set has four operations: a timed wait, a register load, a single-word move and a counted block move with a register stride.

A rising edge on the start input restarts the program at address 0 from any state. The program ends with a zero-length wait, which parks the sequencer until the next start edge. Program memory, the output buffer and the input buffer sit outside the block. They are read through combinational ports, so each instruction finishes in one cycle unless it waits or is stalled. A write into the input buffer completes on a clock edge where the sequencer offers a word and the buffer accepts it.

Top module: `xfer_seq`

## Requirements
- R1: Instruction fields are opcode [31:28], first register [27:24], second register [23:20], third register [19:16] and immediate [15:0]. Fields an operation does not use have no effect.
- R2: Opcodes are 0x0 wait, 0x2 load, 0x8 move and 0x9 block move. Any other opcode halts the sequencer exactly as a zero-length wait does.
- R3: Register 0 always reads as zero, and loads into it are discarded.
- R4: A load writes the sign-extended immediate into the first register and takes one cycle.
- R5: A move reads the output buffer at second register + sign-extended immediate and writes that word to the input buffer at first register + sign-extended immediate. Sums wrap modulo 2^16.
- R6: A block move with a positive signed immediate N performs N transfers. Transfer n (0..N-1) uses source address second register + n*third register and destination address first register + n*third register. An immediate of zero or a negative immediate halts.
- R7: A word is transferred on each edge where ib_we_o and ib_ready_i are both high. While ib_ready_i is low, the write request, both addresses and the data are held.
- R8: A wait with nonzero immediate n, read as unsigned, occupies exactly n cycles before the next instruction executes.
- R9: A wait with immediate 0 halts. While halted, busy_o is low, no write is offered and the program address is held, until a start edge.
- R10: A start edge (start_i high on an edge where it was low on the previous one) sets the program address to 0 and makes busy_o high from the next cycle, from any state, including mid-wait. Register contents are kept.
- R11: After reset, busy_o and ib_we_o are low and pm_addr_o is 0. busy_o is high from the cycle after a start edge until the sequencer halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Rising edge restarts the program at address 0 |
| busy_o | output | 1 | High while the program runs |
| pm_addr_o | output | PC_W | Program memory address (program counter) |
| pm_data_i | input | 32 | Instruction at pm_addr_o, combinational |
| ob_rd_o | output | 1 | Output buffer read request |
| ob_addr_o | output | REG_W | Output buffer read address |
| ob_data_i | input | DATA_W | Output buffer word at ob_addr_o, combinational |
| ib_we_o | output | 1 | Input buffer write request |
| ib_addr_o | output | REG_W | Input buffer write address |
| ib_data_o | output | DATA_W | Word to write |
| ib_ready_i | input | 1 | Input buffer accepts the offered word |

## Verification
Timing is counted from the edge that captures the start request, call it A. The instruction at program address k, when every instruction before it takes one cycle, runs in the cycle that ends at edge A+1+k. A wait of n moves every later event n-1 edges further out, so a move placed right after a wait of n writes on edge A+1+n. The bench stamps each accepted write with the free-running edge count, compares it with these values, and samples every output at the falling edge. Halting is checked one falling edge after it is due and again several cycles later, so the check shows the sequencer stays parked, not only that it paused.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 4;
  localparam int RIDX_W  = 4;
  localparam int IMM_W   = 16;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h2,
    OP_MOV  = 4'h8,
    OP_MOVC = 4'h9
  } opcode_e;

  typedef enum logic [1:0] {
    ST_HALT,
    ST_RUN,
    ST_WAIT
  } state_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] ra;   // destination base
    logic [RIDX_W-1:0] rb;   // source base
    logic [RIDX_W-1:0] rc;   // stride
    logic [IMM_W-1:0]  imm;
  } instr_t;
endpackage

// File: rtl/xs_regfile.sv
module xs_regfile #(
  parameter int NREG  = 16,
  parameter int REG_W = 16,
  parameter int NRD   = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            waddr_i,
  input  logic [REG_W-1:0]            wdata_i,
  input  logic [NRD-1:0][IDX_W-1:0]   raddr_i,
  output logic [NRD-1:0][REG_W-1:0]   rdata_o
);
  logic [REG_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/xs_addr_gen.sv
module xs_addr_gen #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [AW-1:0] offs_i,
  input  logic [AW-1:0] stride_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic [AW-1:0] offs_next_o
);
  assign src_addr_o  = src_base_i + offs_i;
  assign dst_addr_o  = dst_base_i + offs_i;
  assign offs_next_o = offs_i + stride_i;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [PC_W-1:0]   pm_addr_o,
  input  logic [INSTR_W-1:0] pm_data_i,
  output logic              ob_rd_o,
  output logic [REG_W-1:0]  ob_addr_o,
  input  logic [DATA_W-1:0] ob_data_i,
  output logic              ib_we_o,
  output logic [REG_W-1:0]  ib_addr_o,
  output logic [DATA_W-1:0] ib_data_o,
  input  logic              ib_ready_i
);
  localparam int NREG = 1 << RIDX_W;

  state_e            state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [IMM_W-1:0]  wait_q, wait_d;
  logic [IMM_W-1:0]  iter_q, iter_d;
  logic [REG_W-1:0]  offs_q, offs_d;
  logic              start_q;

  instr_t            ins;
  logic [REG_W-1:0]  imm_sx;
  logic [2:0][RIDX_W-1:0] rf_raddr;
  logic [2:0][REG_W-1:0]  rf_rdata;
  logic              rf_we;
  logic              start_rise;
  logic              is_mov, is_movc, movc_bad, xfer_act, last_iter;
  logic [REG_W-1:0]  offs_sel, offs_next;

  assign ins        = instr_t'(pm_data_i);
  assign imm_sx     = REG_W'($signed(ins.imm));
  assign start_rise = start_i & ~start_q;

  assign is_mov   = (ins.opc == OP_MOV);
  assign is_movc  = (ins.opc == OP_MOVC);
  assign movc_bad = ins.imm[IMM_W-1] || (ins.imm == '0);
  assign xfer_act = (state_q == ST_RUN) && (is_mov || (is_movc && !movc_bad));
  assign last_iter = is_mov || (iter_q == ins.imm - IMM_W'(1));
  assign offs_sel  = is_movc ? offs_q : imm_sx;

  assign rf_raddr = {ins.rc, ins.rb, ins.ra};
  assign rf_we    = (state_q == ST_RUN) && (ins.opc == OP_LDI);

  xs_regfile #(
    .NREG (NREG),
    .REG_W(REG_W),
    .NRD  (3)
  ) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .waddr_i(ins.ra),
    .wdata_i(imm_sx),
    .raddr_i(rf_raddr),
    .rdata_o(rf_rdata)
  );

  xs_addr_gen #(
    .AW(REG_W)
  ) i_addr_gen (
    .src_base_i (rf_rdata[1]),
    .dst_base_i (rf_rdata[0]),
    .offs_i     (offs_sel),
    .stride_i   (rf_rdata[2]),
    .src_addr_o (ob_addr_o),
    .dst_addr_o (ib_addr_o),
    .offs_next_o(offs_next)
  );

  assign ob_rd_o   = xfer_act;
  assign ib_we_o   = xfer_act;
  assign ib_data_o = ob_data_i;
  assign busy_o    = (state_q != ST_HALT);
  assign pm_addr_o = pc_q;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    wait_d  = wait_q;
    iter_d  = iter_q;
    offs_d  = offs_q;
    case (state_q)
      ST_RUN: begin
        case (ins.opc)
          OP_NOP: begin
            if (ins.imm == '0) begin
              state_d = ST_HALT;
            end else if (ins.imm == IMM_W'(1)) begin
              pc_d = pc_q + PC_W'(1);
            end else begin
              wait_d  = ins.imm - IMM_W'(1);
              state_d = ST_WAIT;
            end
          end
          OP_LDI: pc_d = pc_q + PC_W'(1);
          OP_MOV, OP_MOVC: begin
            if (is_movc && movc_bad) begin
              state_d = ST_HALT;
            end else if (ib_ready_i) begin
              if (last_iter) begin
                pc_d   = pc_q + PC_W'(1);
                iter_d = '0;
                offs_d = '0;
              end else begin
                iter_d = iter_q + IMM_W'(1);
                offs_d = offs_next;
              end
            end
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_WAIT: begin
        if (wait_q == IMM_W'(1)) begin
          pc_d    = pc_q + PC_W'(1);
          state_d = ST_RUN;
        end else begin
          wait_d = wait_q - IMM_W'(1);
        end
      end
      default: ;
    endcase
    if (start_rise) begin
      state_d = ST_RUN;
      pc_d    = '0;
      wait_d  = '0;
      iter_d  = '0;
      offs_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HALT;
      pc_q    <= '0;
      wait_q  <= '0;
      iter_q  <= '0;
      offs_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      wait_q  <= wait_d;
      iter_q  <= iter_d;
      offs_q  <= offs_d;
      start_q <= start_i;
    end
  end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int PC_W  = 8,
  parameter int REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic [PC_W-1:0]  pm_addr_o,
  input logic             ib_we_o,
  input logic             ib_ready_i,
  input logic [REG_W-1:0] ib_addr_o,
  input logic [REG_W-1:0] ob_addr_o
);
  logic start_d;
  logic start_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_d <= 1'b0;
    else         start_d <= start_i;
  end
  assign start_edge = start_i && !start_d;

  a_r11_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_we_o |-> busy_o);

  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ib_we_o && !ib_ready_i && !start_edge) |=>
      (ib_we_o && $stable(ib_addr_o) && $stable(ob_addr_o)));

  a_r10_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_edge |=> (busy_o && pm_addr_o == '0));

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(pm_addr_o)));
endmodule

bind xfer_seq xfer_seq_chk #(
  .PC_W (PC_W),
  .REG_W(REG_W)
) i_xfer_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .pm_addr_o (pm_addr_o),
  .ib_we_o   (ib_we_o),
  .ib_ready_i(ib_ready_i),
  .ib_addr_o (ib_addr_o),
  .ob_addr_o (ob_addr_o)
);

// File: tb/test_xfer_seq.sv
module test_xfer_seq;
  localparam int PC_W = 8;
  localparam int REG_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              busy;
  logic [PC_W-1:0]   pm_addr;
  logic [31:0]       pm_data;
  logic              ob_rd;
  logic [REG_W-1:0]  ob_addr;
  logic [DATA_W-1:0] ob_data;
  logic              ib_we;
  logic [REG_W-1:0]  ib_addr;
  logic [DATA_W-1:0] ib_data;
  logic              ib_ready = 1'b1;
  logic              stall_mode = 1'b0;

  logic [31:0] pm [256];
  logic [31:0] wl_addr [64];
  logic [31:0] wl_data [64];
  int          wl_cyc  [64];
  int cyc = 0;
  int wcnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign pm_data = pm[pm_addr];
  assign ob_data = 32'hA500_0000 | {16'h0, ob_addr};

  xfer_seq #(.DATA_W(DATA_W), .PC_W(PC_W), .REG_W(REG_W)) i_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy),
    .pm_addr_o(pm_addr), .pm_data_i(pm_data),
    .ob_rd_o(ob_rd), .ob_addr_o(ob_addr), .ob_data_i(ob_data),
    .ib_we_o(ib_we), .ib_addr_o(ib_addr), .ib_data_o(ib_data), .ib_ready_i(ib_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ib_we && ib_ready) begin
      if (wcnt < 64) begin
        wl_addr[wcnt] <= {16'h0, ib_addr};
        wl_data[wcnt] <= ib_data;
        wl_cyc[wcnt]  <= cyc;
      end
      wcnt <= wcnt + 1;
    end
  end

  always @(negedge clk) ib_ready <= stall_mode ? (cyc % 3 == 2) : 1'b1;

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] ra,
                                      input logic [3:0] rb, input logic [3:0] rc,
                                      input logic [15:0] imm);
    return {op, ra, rb, rc, imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_pm();
    for (int i = 0; i < 256; i++) pm[i] = 32'h0;
  endtask

  task automatic run(output int s, input int limit);
    @(negedge clk);
    start = 1'b1;
    s = cyc;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", "busy after reset", {31'h0, busy}, 32'h0);
    chk("R11", "we after reset", {31'h0, ib_we}, 32'h0);
    chk("R11", "pc after reset", {24'h0, pm_addr}, 32'h0);
  endtask

  task automatic t_ldi_mov();
    int s, b;
    clear_pm();
    pm[0] = enc(4'h2, 4'd1, 4'd7, 4'd9, 16'd5);   // junk in unused fields (R1)
    pm[1] = enc(4'h2, 4'd2, 4'd0, 4'd0, 16'd10);
    pm[2] = enc(4'h8, 4'd2, 4'd1, 4'd0, 16'd3);
    b = wcnt;
    run(s, 100);
    chk("R5", "mov count", wcnt - b, 1);
    chk("R5", "mov dst", wl_addr[b], 32'd13);
    chk("R1", "mov data", wl_data[b], 32'hA500_0008);
    chk("R4", "mov cycle", wl_cyc[b], s + 3);
    chk("R11", "busy low at end", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_neg_imm();
    int s, b;
    clear_pm();
    pm[0] = enc(4'h2, 4'd1, 4'd0, 4'd0, 16'd20);
    pm[1] = enc(4'h2, 4'd3, 4'd0, 4'd0, 16'hFFFE);
    pm[2] = enc(4'h8, 4'd1, 4'd3, 4'd0, 16'hFFFC);
    b = wcnt;
    run(s, 100);
    chk("R5", "neg dst", wl_addr[b], 32'd16);
    chk("R5", "wrap src data", wl_data[b], 32'hA500_FFFA);
  endtask

  task automatic t_reg0();
    int s, b;
    clear_pm();
    pm[0] = enc(4'h2, 4'd0, 4'd0, 4'd0, 16'd7);
    pm[1] = enc(4'h8, 4'd0, 4'd0, 4'd0, 16'd2);
    b = wcnt;
    run(s, 100);
    chk("R3", "r0 dst", wl_addr[b], 32'd2);
    chk("R3", "r0 data", wl_data[b], 32'hA500_0002);
  endtask

  task automatic t_movc();
    int s, b;
    clear_pm();
    pm[0] = enc(4'h2, 4'd1, 4'd0, 4'd0, 16'd100);
    pm[1] = enc(4'h2, 4'd2, 4'd0, 4'd0, 16'd200);
    pm[2] = enc(4'h2, 4'd3, 4'd0, 4'd0, 16'd3);
    pm[3] = enc(4'h9, 4'd2, 4'd1, 4'd3, 16'd4);
    stall_mode = 1'b1;
    b = wcnt;
    run(s, 200);
    stall_mode = 1'b0;
    chk("R6", "movc count stalled", wcnt - b, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R6", "movc dst", wl_addr[b + k], 32'd200 + 32'(3 * k));
      chk("R7", "movc data", wl_data[b + k], 32'hA500_0000 + 32'd100 + 32'(3 * k));
    end
    @(negedge clk);
    b = wcnt;
    run(s, 200);
    chk("R6", "movc count", wcnt - b, 4);
    chk("R7", "first burst cycle", wl_cyc[b], s + 4);
    chk("R7", "back to back", wl_cyc[b + 3] - wl_cyc[b], 3);
  endtask

  task automatic t_nop();
    int s, b;
    clear_pm();
    pm[0] = enc(4'h0, 4'd0, 4'd0, 4'd0, 16'd5);
    pm[1] = enc(4'h8, 4'd0, 4'd0, 4'd0, 16'd50);
    b = wcnt;
    run(s, 100);
    chk("R8", "nop5 write cycle", wl_cyc[b], s + 6);
    pm[0] = enc(4'h0, 4'd0, 4'd0, 4'd0, 16'd1);
    b = wcnt;
    run(s, 100);
    chk("R8", "nop1 write cycle", wl_cyc[b], s + 2);
    pm[0] = enc(4'h0, 4'd0, 4'd0, 4'd0, 16'h8002);
    b = wcnt;
    run(s, 40000);
    chk("R8", "unsigned nop cycle", wl_cyc[b], s + 1 + 32770);
  endtask

  task automatic t_halts();
    int s, b;
    logic [31:0] bad [3];
    bad[0] = 32'hF000_1234;
    bad[1] = enc(4'h9, 4'd0, 4'd0, 4'd0, 16'd0);
    bad[2] = enc(4'h9, 4'd0, 4'd0, 4'd0, 16'hFFFF);
    for (int i = 0; i < 3; i++) begin
      clear_pm();
      pm[0] = bad[i];
      pm[1] = enc(4'h8, 4'd0, 4'd0, 4'd0, 16'd60);
      b = wcnt;
      run(s, 100);
      repeat (5) @(negedge clk);
      chk(i == 0 ? "R2" : "R6", "halt no write", wcnt - b, 0);
      chk("R9", "halt pc held", {24'h0, pm_addr}, 32'h0);
      chk("R9", "halt busy", {31'h0, busy}, 32'h0);
    end
    clear_pm();
    pm[0] = enc(4'h8, 4'd0, 4'd0, 4'd0, 16'd61);
    pm[2] = enc(4'h8, 4'd0, 4'd0, 4'd0, 16'd62);
    b = wcnt;
    run(s, 100);
    repeat (5) @(negedge clk);
    chk("R9", "nop0 single write", wcnt - b, 1);
    chk("R9", "nop0 pc held", {24'h0, pm_addr}, 32'h1);
    chk("R9", "nop0 no we", {31'h0, ib_we}, 32'h0);
  endtask

  task automatic t_restart();
    int s1, s2, b;
    clear_pm();
    pm[0] = enc(4'h2, 4'd5, 4'd0, 4'd0, 16'd40);
    run(s1, 100);
    pm[0] = enc(4'h0, 4'd0, 4'd0, 4'd0, 16'd300);
    pm[1] = enc(4'h8, 4'd5, 4'd5, 4'd0, 16'd0);
    pm[2] = 32'h0;
    b = wcnt;
    @(negedge clk);
    start = 1'b1;
    s1 = cyc;
    repeat (10) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    s2 = cyc;
    @(negedge clk);
    chk("R10", "busy after restart", {31'h0, busy}, 32'h1);
    chk("R10", "pc after restart", {24'h0, pm_addr}, 32'h0);
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    start = 1'b0;
    chk("R10", "restart write count", wcnt - b, 1);
    chk("R10", "restart write cycle", wl_cyc[b], s2 + 301);
    chk("R10", "register kept", wl_addr[b], 32'd40);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_pm();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ldi_mov();
    t_neg_imm();
    t_reg0();
    t_movc();
    t_nop();
    t_halts();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule